// File: doc/BRIEF.md
# Serial CRC Generator and Checker for an SPI Shift Engine

This unit sits next to an SPI shift engine and keeps two bit-serial CRC accumulators. One covers the bits the engine sends and the other covers the bits it receives. Each accumulator advances one bit per sample strobe. The shift engine raises that strobe on its data sampling edge, and the clock polarity and phase settings decide which edge that is. Software supplies the generator polynomial. A frame-format select chooses an 8-bit CRC for 8-bit frames or a 16-bit CRC for 16-bit frames.

Software asks for the checksum by pulsing a "CRC next" request during the last data frame. It does this right after loading the final transmit word, or in receive-only operation right after the second-to-last word arrives. When the current frame ends, the unit marks the following frame as the CRC frame. If a data word is still waiting in the transmit buffer, the CRC frame starts only after that word has gone out.

During the CRC frame the shift engine sends `crc_word` MSB first, and both accumulators hold still. At the end of the CRC frame, the word that was received is compared with the locally computed receive CRC. A mismatch sets a sticky error flag.

Top module: `spi_crc_unit`

## Requirements
- R1: With `crc_en` high, `crc_phase` low and `wide_frame`=1, each cycle with `sample_stb` high updates `tx_crc` as follows. The register shifts left by one. If the old bit 15 XOR `tx_bit` is 1, the result is XORed with `poly`. The CRC starts from zero, is MSB-first, is not reflected and has no final XOR.
- R2: `rx_crc` follows the same rule driven by `rx_bit`, independently of the transmit side.
- R3: With `wide_frame`=0, both CRCs use bits 7:0 only. Bit 7 is the MSB, only `poly[7:0]` is used, and bits 15:8 stay zero.
- R4: Cycles with `sample_stb` low change neither CRC register, whatever `tx_bit` and `rx_bit` are doing.
- R5: While `crc_en` is low, both CRC registers are zero and `crc_phase` is low. Raising `crc_en` therefore starts from cleared registers.
- R6: A `crc_next` pulse during a frame makes `crc_phase` high from the cycle after that frame's `frame_done`. `crc_word` equals `tx_crc` in 16-bit mode and `{tx_crc[7:0], 8'h00}` in 8-bit mode.
- R7: If `tx_buf_full` is high at the `frame_done` that would end a pending request, `crc_phase` stays low. It goes high after the end of the next frame instead.
- R8: While `crc_phase` is high, neither CRC register changes.
- R9: At `frame_done` in the CRC frame, `crc_phase` clears. If the received word (the last 8 or 16 sampled `rx_bit`s, MSB first) differs from `rx_crc`, `crc_err` is set.
- R10: A received CRC word that matches leaves `crc_err` low.
- R11: `crc_err` stays high through later frames until `err_clr` is pulsed. A new mismatch in the same cycle as `err_clr` wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| crc_en | input | 1 | CRC enable; low clears all CRC state |
| wide_frame | input | 1 | 1 = 16-bit frames/CRC, 0 = 8-bit |
| poly | input | 16 | Generator polynomial (implicit top term) |
| sample_stb | input | 1 | One bit sampled this cycle |
| tx_bit | input | 1 | Transmitted bit at the sample |
| rx_bit | input | 1 | Received bit at the sample |
| frame_done | input | 1 | Qualifies the last bit of a frame |
| crc_next | input | 1 | Request to send or receive the CRC after the current frame |
| tx_buf_full | input | 1 | Another data word waits for transmission |
| err_clr | input | 1 | Clears the CRC error flag |
| tx_crc | output | 16 | Transmit CRC register |
| rx_crc | output | 16 | Receive CRC register |
| crc_word | output | 16 | CRC to shift out MSB first, left-aligned |
| crc_phase | output | 1 | Current frame is the CRC frame |
| crc_err | output | 1 | Sticky CRC mismatch flag |

## Verification
The assertions assume `frame_done` is only high together with `sample_stb`. They also assume `wide_frame` and `poly` stay constant while a frame sequence is running, because a change mid-sequence would leave stale upper bits. The stimulus changes the format and polynomial only while `crc_en` is low. It drives `frame_done` only on the last bit of each 8- or 16-bit frame and pulses `crc_next` only inside a data frame.

// File: rtl/spi_crc_pkg.sv
package spi_crc_pkg;

   localparam int unsigned CRC_MAX_W = 32;

   typedef enum logic {
      FMT_NARROW = 1'b0,
      FMT_WIDE   = 1'b1
   } frame_fmt_e;

   // One serial step: shift left, fold in the polynomial when msb ^ din
   function automatic logic [CRC_MAX_W-1:0] crc_step(
      input logic [CRC_MAX_W-1:0] cur,
      input logic                 din,
      input logic [CRC_MAX_W-1:0] poly,
      input int unsigned          w
   );
      logic [CRC_MAX_W-1:0] mask;
      logic [CRC_MAX_W-1:0] nxt;
      logic                 fb;
      mask = (w >= CRC_MAX_W) ? '1 : ((CRC_MAX_W'(1) << w) - CRC_MAX_W'(1));
      fb   = cur[w-1] ^ din;
      nxt  = (cur << 1) & mask;
      if (fb) nxt = nxt ^ (poly & mask);
      return nxt;
   endfunction

endpackage

// File: rtl/crc_lfsr.sv
module crc_lfsr #(
   parameter int unsigned CRC_W    = 16,
   parameter int unsigned NARROW_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             stb,
   input  logic             freeze,
   input  logic             wide,
   input  logic             din,
   input  logic [CRC_W-1:0] poly,
   output logic [CRC_W-1:0] crc
);
   import spi_crc_pkg::*;

   logic [CRC_W-1:0] nxt;
   logic [CRC_MAX_W-1:0] step_out;
   int unsigned          cur_w;

   generate
      if (CRC_W == NARROW_W) begin : g_fixed
         assign cur_w = CRC_W;
      end else begin : g_sel
         assign cur_w = wide ? CRC_W : NARROW_W;
      end
   endgenerate

   always_comb begin
      step_out = crc_step(CRC_MAX_W'(crc), din, CRC_MAX_W'(poly), cur_w);
      nxt      = step_out[CRC_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               crc <= '0;
      else if (!en)             crc <= '0;
      else if (stb && !freeze)  crc <= nxt;
   end

   // R8
   freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && freeze) |=> (crc == $past(crc)));
   // R4
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !stb) |=> $stable(crc));
   // R5
   disabled_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (crc == '0));
endmodule

// File: rtl/crc_seq.sv
module crc_seq (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic frame_end,
   input  logic req,
   input  logic buf_full,
   output logic phase
);
   logic pending;
   logic want;

   assign want = pending | req;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pending <= 1'b0;
         phase   <= 1'b0;
      end else if (!en) begin
         pending <= 1'b0;
         phase   <= 1'b0;
      end else if (frame_end && phase) begin
         phase   <= 1'b0;
         pending <= req;
      end else if (frame_end && want && !buf_full) begin
         phase   <= 1'b1;
         pending <= 1'b0;
      end else if (req) begin
         pending <= 1'b1;
      end
   end

   // R6
   phase_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(phase) |-> $past(frame_end));
   // R7
   buf_defer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_end && buf_full && !phase) |=> !phase);
endmodule

// File: rtl/crc_cmp.sv
module crc_cmp #(
   parameter int unsigned CRC_W    = 16,
   parameter int unsigned NARROW_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             stb,
   input  logic             wide,
   input  logic             din,
   input  logic             check_now,
   input  logic [CRC_W-1:0] ref_crc,
   input  logic             clr,
   output logic             err
);
   localparam logic [CRC_W-1:0] NARROW_MASK = CRC_W'((64'd1 << NARROW_W) - 64'd1);

   logic [CRC_W-1:0] shift_q;
   logic [CRC_W-1:0] word_in;
   logic [CRC_W-1:0] mask;
   logic             mismatch;

   assign word_in  = {shift_q[CRC_W-2:0], din};
   assign mask     = wide ? '1 : NARROW_MASK;
   assign mismatch = ((word_in ^ ref_crc) & mask) != '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            shift_q <= '0;
      else if (en && stb)    shift_q <= word_in;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       err <= 1'b0;
      else if (check_now && mismatch)   err <= 1'b1;
      else if (clr)                     err <= 1'b0;
   end

   // R11
   err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (err && !clr) |=> err);
   // R9
   err_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err) |-> $past(check_now));
endmodule

// File: rtl/spi_crc_unit.sv
module spi_crc_unit #(
   parameter int unsigned CRC_W    = 16,
   parameter int unsigned NARROW_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             crc_en,
   input  logic             wide_frame,
   input  logic [CRC_W-1:0] poly,
   input  logic             sample_stb,
   input  logic             tx_bit,
   input  logic             rx_bit,
   input  logic             frame_done,
   input  logic             crc_next,
   input  logic             tx_buf_full,
   input  logic             err_clr,
   output logic [CRC_W-1:0] tx_crc,
   output logic [CRC_W-1:0] rx_crc,
   output logic [CRC_W-1:0] crc_word,
   output logic             crc_phase,
   output logic             crc_err
);
   localparam int unsigned N_CH = 2;

   generate
      if (CRC_W > spi_crc_pkg::CRC_MAX_W || NARROW_W > CRC_W || NARROW_W < 2) begin : g_bad_cfg
         $error("spi_crc_unit: unsupported CRC_W/NARROW_W");
      end
   endgenerate

   logic             frame_end;
   logic [N_CH-1:0]  ch_bit;
   logic [CRC_W-1:0] ch_crc [N_CH];

   assign frame_end = sample_stb & frame_done;
   assign ch_bit    = {rx_bit, tx_bit};

   genvar ch;
   generate
      for (ch = 0; ch < N_CH; ch++) begin : g_ch
         crc_lfsr #(.CRC_W(CRC_W), .NARROW_W(NARROW_W)) i_lfsr (
            .clk    (clk),
            .rst_n  (rst_n),
            .en     (crc_en),
            .stb    (sample_stb),
            .freeze (crc_phase),
            .wide   (wide_frame),
            .din    (ch_bit[ch]),
            .poly   (poly),
            .crc    (ch_crc[ch])
         );
      end
   endgenerate

   assign tx_crc = ch_crc[0];
   assign rx_crc = ch_crc[1];

   generate
      if (CRC_W == NARROW_W) begin : g_word_fixed
         assign crc_word = tx_crc;
      end else begin : g_word_sel
         assign crc_word = wide_frame ? tx_crc
                                      : {tx_crc[NARROW_W-1:0], {(CRC_W-NARROW_W){1'b0}}};
      end
   endgenerate

   crc_seq i_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (crc_en),
      .frame_end (frame_end),
      .req       (crc_next),
      .buf_full  (tx_buf_full),
      .phase     (crc_phase)
   );

   crc_cmp #(.CRC_W(CRC_W), .NARROW_W(NARROW_W)) i_cmp (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (crc_en),
      .stb       (sample_stb),
      .wide      (wide_frame),
      .din       (rx_bit),
      .check_now (frame_end & crc_phase),
      .ref_crc   (rx_crc),
      .clr       (err_clr),
      .err       (crc_err)
   );
endmodule

// File: tb/test_spi_crc_unit.sv
module test_spi_crc_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        crc_en = 1'b0, wide_frame = 1'b1;
   logic [15:0] poly = 16'h0;
   logic        sample_stb = 1'b0, tx_bit = 1'b0, rx_bit = 1'b0;
   logic        frame_done = 1'b0, crc_next = 1'b0, tx_buf_full = 1'b0, err_clr = 1'b0;
   logic [15:0] tx_crc, rx_crc, crc_word;
   logic        crc_phase, crc_err;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #10 clk = ~clk;

   spi_crc_unit i_spi_crc_unit (
      .clk(clk), .rst_n(rst_n), .crc_en(crc_en), .wide_frame(wide_frame), .poly(poly),
      .sample_stb(sample_stb), .tx_bit(tx_bit), .rx_bit(rx_bit), .frame_done(frame_done),
      .crc_next(crc_next), .tx_buf_full(tx_buf_full), .err_clr(err_clr),
      .tx_crc(tx_crc), .rx_crc(rx_crc), .crc_word(crc_word),
      .crc_phase(crc_phase), .crc_err(crc_err)
   );

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] model(input logic [15:0] r, input logic [15:0] word,
                                         input int n, input logic [15:0] p);
      logic [15:0] m;
      m = (n == 16) ? 16'hFFFF : 16'h00FF;
      for (int i = n - 1; i >= 0; i--) begin
         if ((((r >> (n - 1)) & 16'h1) ^ ((word >> i) & 16'h1)) != 0)
            r = ((r * 2) & m) ^ (p & m);
         else
            r = (r * 2) & m;
      end
      return r;
   endfunction

   task automatic send_frame(input logic [15:0] tw, input logic [15:0] rw, input int n,
                             input bit nxt, input bit bfull);
      for (int i = n - 1; i >= 0; i--) begin
         @(negedge clk);
         sample_stb  = 1'b1;
         tx_bit      = tw[i];
         rx_bit      = rw[i];
         frame_done  = (i == 0);
         crc_next    = nxt && (i == n - 1);
         tx_buf_full = bfull && (i == 0);
      end
      @(negedge clk);
      sample_stb = 1'b0; frame_done = 1'b0; crc_next = 1'b0; tx_buf_full = 1'b0;
   endtask

   task automatic restart(input bit w, input logic [15:0] p);
      @(negedge clk);
      crc_en = 1'b0; wide_frame = w; poly = p;
      @(negedge clk);
      // R5: disabled clears both
      check("R5 tx_crc cleared", tx_crc, 16'h0);
      check("R5 rx_crc cleared", rx_crc, 16'h0);
      check("R5 phase low", {15'h0, crc_phase}, 16'h0);
      crc_en = 1'b1;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [15:0] mtx, mrx, tw, rw, m, p, stx, srx;
      int n;
      repeat (3) @(negedge clk);
      check("reset tx_crc", tx_crc, 16'h0);
      check("reset rx_crc", rx_crc, 16'h0);
      check("reset err", {15'h0, crc_err}, 16'h0);
      rst_n = 1'b1;

      for (int w = 0; w < 2; w++) begin
         for (int pi = 0; pi < 3; pi++) begin
            n = w ? 16 : 8;
            m = w ? 16'hFFFF : 16'h00FF;
            case (pi)
               0: p = w ? 16'h8005 : 16'h0007;
               1: p = w ? 16'h1021 : 16'h0031;
               default: p = w ? 16'h3D65 : 16'h009B;
            endcase
            // upper poly bits set in narrow mode must not matter (R3)
            restart(w[0], w ? p : (p | 16'hA500));
            mtx = 16'h0; mrx = 16'h0;
            for (int f = 0; f < 4; f++) begin
               tw = (16'(f) * 16'h03A5 + 16'h01B7 + 16'(pi) * 16'h1111) & m;
               rw = (tw ^ 16'h5A3C ^ (16'(f) << 3)) & m;
               send_frame(tw, rw, n, f == 3, 1'b0);
               mtx = model(mtx, tw, n, p);
               mrx = model(mrx, rw, n, p);
            end
            check(w ? "R1 tx_crc 16-bit" : "R3 tx_crc 8-bit", tx_crc, mtx);
            check(w ? "R2 rx_crc 16-bit" : "R3 rx_crc 8-bit", rx_crc, mrx);
            check("R6 phase after request", {15'h0, crc_phase}, 16'h1);
            check("R6 crc_word", crc_word, w ? mtx : (mtx << 8));
            // R4: bits toggle without strobe
            for (int k = 0; k < 5; k++) begin
               @(negedge clk); tx_bit = k[0]; rx_bit = ~k[0];
            end
            @(negedge clk);
            check("R4 tx held w/o strobe", tx_crc, mtx);
            check("R4 rx held w/o strobe", rx_crc, mrx);
            // CRC frame; pi==1 gets a corrupted received CRC
            send_frame(mtx, (pi == 1) ? (mrx ^ 16'h0001) : mrx, n, 1'b0, 1'b0);
            check("R8 tx frozen in CRC frame", tx_crc, mtx);
            check("R8 rx frozen in CRC frame", rx_crc, mrx);
            check("R9 phase cleared", {15'h0, crc_phase}, 16'h0);
            if (pi == 1) begin
               check("R9 mismatch sets err", {15'h0, crc_err}, 16'h1);
               send_frame(16'h00F0 & m, 16'h0F0F & m, n, 1'b0, 1'b0);
               check("R11 err sticky", {15'h0, crc_err}, 16'h1);
               @(negedge clk); err_clr = 1'b1;
               @(negedge clk); err_clr = 1'b0;
               check("R11 err cleared", {15'h0, crc_err}, 16'h0);
            end else begin
               check("R10 match no err", {15'h0, crc_err}, 16'h0);
            end
         end
      end

      // R7: buffered word defers the CRC frame
      restart(1'b1, 16'h8005);
      send_frame(16'h1234, 16'h4321, 16, 1'b1, 1'b1);
      check("R7 deferred while buffer full", {15'h0, crc_phase}, 16'h0);
      send_frame(16'hBEEF, 16'hCAFE, 16, 1'b0, 1'b0);
      check("R7 phase after buffered frame", {15'h0, crc_phase}, 16'h1);
      stx = model(model(16'h0, 16'h1234, 16, 16'h8005), 16'hBEEF, 16, 16'h8005);
      srx = model(model(16'h0, 16'h4321, 16, 16'h8005), 16'hCAFE, 16, 16'h8005);
      check("R7 tx includes buffered frame", tx_crc, stx);
      send_frame(stx, srx, 16, 1'b0, 1'b0);
      check("R10 match after deferral", {15'h0, crc_err}, 16'h0);

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule